// File: doc/BRIEF.md
# Programmable debug request generator

This block drives a debug request line toward a processor core, and one 32-bit control word written into it sets its behaviour. The word carries the value to drive onto the line. It also selects one of two modes. In level mode the line moves to the new value and stays there. In pulse mode the line holds the value for a number of clocks and then returns to the opposite value. The change happens after a start delay. The delay and the pulse width can each be a fixed clock count or a random draw bounded by a programmed maximum.

Random draws come from a free-running 32-bit LFSR inside the block. Each draw is reduced modulo (maximum + 1). A busy output stays high from the write until the sequence completes. Any write restarts the generator, including one that arrives while a sequence is running. Bus address decoding is outside the block. So is the core's response to the request.

Top module: `dbgreq_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `dbg_req_o` is 0 and `busy_o` is 0.
- R2: `busy_o` is 1 in the cycle after a write is sampled and stays 1 until the sequence completes. While `busy_o` is 0 and no write is sampled, `dbg_req_o` does not change.
- R3: With bit 15 of the word at 0, bits 14:0 give a fixed delay D. The output takes the bit 31 value at the (D+1)th rising edge after the edge that samples the write, so a delay of 0 changes it on the next edge.
- R4: With bit 30 at 0 (level mode), the output takes the bit 31 value after the delay and holds it until a later write. `busy_o` falls on the same edge.
- R5: With bit 30 at 1 (pulse mode) and bit 29 at 0, the output holds the bit 31 value for P clocks, where P is bits 28:16. It then takes the inverse of bit 31 on the edge where `busy_o` falls.
- R6: A pulse width of 0 in bits 28:16 gives a one-clock pulse.
- R7: With bit 15 at 1, the delay is a random value in 0 to the bits 14:0 maximum. A maximum of 0 gives a delay of 0.
- R8: With bit 29 at 1, the pulse width is a random value reduced into 0 to the bits 28:16 maximum, and a result of 0 is raised to 1. The pulse therefore lasts 1 to max(1, maximum) clocks.
- R9: Random draws come from a free-running LFSR, so repeated writes with the same random word yield different values.
- R10: A write sampled while busy aborts the running sequence and restarts with the new word. The output keeps its present value until the new sequence applies its change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word |
| dbg_req_o | output | 1 | Debug request toward the core |
| busy_o | output | 1 | High while a delay or a pulse is running |

## Verification
The assertions check, on every cycle, the reset state and the rise of busy after each write. They also check that the output never moves while the generator is idle, and that a fixed zero-delay level write lands on the next edge. Only the bench scenarios can show the exact cycle counts of non-zero delays and pulse widths, the bounds and variety of random draws, and the abort of a running delay or pulse by a new write.

// File: rtl/dbgreq_pkg.sv
package dbgreq_pkg;
  localparam int CTRL_W = 32;
  localparam int DLY_W  = 15;
  localparam int DUR_W  = 13;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } dreq_state_e;

  // Field order follows the bit layout of the control word, MSB first.
  typedef struct packed {
    logic             value;
    logic             pulse;
    logic             dur_rand;
    logic [DUR_W-1:0] dur;
    logic             dly_rand;
    logic [DLY_W-1:0] dly;
  } dreq_ctrl_t;
endpackage

// File: rtl/dbgreq_lfsr.sv
module dbgreq_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C,
  parameter logic [W-1:0] TAPS = 32'hA300_0000
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] q;

  // Right-shifting Galois register, advances every cycle.
  always_ff @(posedge clk_i) begin
    if (rst_i) q <= SEED;
    else       q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  assign rnd_o = q;
endmodule

// File: rtl/dbgreq_pick.sv
module dbgreq_pick #(
  parameter int VAL_W = 15,
  parameter int RND_W = 32
) (
  input  logic             rand_sel_i,
  input  logic [VAL_W-1:0] limit_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [VAL_W-1:0] val_o
);
  logic [RND_W-1:0] span;
  logic [RND_W-1:0] red;

  always_comb begin
    span  = RND_W'(limit_i) + RND_W'(1);
    red   = rnd_i % span;
    val_o = rand_sel_i ? red[VAL_W-1:0] : limit_i;
  end
endmodule

// File: rtl/dbgreq_gen.sv
module dbgreq_gen
  import dbgreq_pkg::*;
#(
  parameter int          RND_W = 32,
  parameter logic [31:0] SEED  = 32'h1ACE_B00C
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              dbg_req_o,
  output logic              busy_o
);
  localparam int CNT_W = (DLY_W > DUR_W) ? DLY_W : DUR_W;
  localparam int HALF  = RND_W / 2;

  dreq_ctrl_t       ctrl;
  logic [RND_W-1:0] rnd;
  logic [RND_W-1:0] rnd_rot;
  logic [DLY_W-1:0] dly_pick;
  logic [DUR_W-1:0] dur_pick;
  logic [DUR_W-1:0] dur_eff;

  dreq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DUR_W-1:0] dur_q;
  logic             val_q;
  logic             pulse_q;
  logic             req_q;

  assign ctrl    = dreq_ctrl_t'(wr_data_i);
  assign rnd_rot = {rnd[HALF-1:0], rnd[RND_W-1:HALF]};

  dbgreq_lfsr #(.W(RND_W), .SEED(RND_W'(SEED))) lfsr_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .rnd_o (rnd)
  );

  dbgreq_pick #(.VAL_W(DLY_W), .RND_W(RND_W)) dly_pick_i (
    .rand_sel_i (ctrl.dly_rand),
    .limit_i    (ctrl.dly),
    .rnd_i      (rnd),
    .val_o      (dly_pick)
  );

  dbgreq_pick #(.VAL_W(DUR_W), .RND_W(RND_W)) dur_pick_i (
    .rand_sel_i (ctrl.dur_rand),
    .limit_i    (ctrl.dur),
    .rnd_i      (rnd_rot),
    .val_o      (dur_pick)
  );

  // A zero width still yields a one-clock pulse.
  assign dur_eff = (dur_pick == '0) ? DUR_W'(1) : dur_pick;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dur_q   <= '0;
      val_q   <= 1'b0;
      pulse_q <= 1'b0;
      req_q   <= 1'b0;
    end else if (wr_en_i) begin
      // Any write, busy or not, starts a fresh sequence.
      state_q <= ST_WAIT;
      cnt_q   <= CNT_W'(dly_pick);
      dur_q   <= dur_eff;
      val_q   <= ctrl.value;
      pulse_q <= ctrl.pulse;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (cnt_q == '0) begin
            req_q <= val_q;
            if (pulse_q) begin
              state_q <= ST_HOLD;
              cnt_q   <= CNT_W'(dur_q - DUR_W'(1));
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            req_q   <= ~val_q;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dbg_req_o = req_q;
  assign busy_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/dbgreq_gen_chk.sv
module dbgreq_gen_chk (
  input logic        clk_i,
  input logic        rst_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        dbg_req_o,
  input logic        busy_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (!dbg_req_o && !busy_o));

  // R2
  busy_after_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> busy_o);

  // R2
  idle_output_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && !wr_en_i) |=> (dbg_req_o == $past(dbg_req_o)));

  // R3
  zero_delay_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !wr_data_i[30] && !wr_data_i[15] && (wr_data_i[14:0] == 15'd0))
      ##1 !wr_en_i |=> ((dbg_req_o == $past(wr_data_i[31], 2)) && !busy_o));
endmodule

bind dbgreq_gen dbgreq_gen_chk chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .dbg_req_o (dbg_req_o),
  .busy_o    (busy_o)
);

// File: tb/dbgreq_gen_tb_top.sv
module dbgreq_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        dbg_req;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgreq_gen dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .dbg_req_o (dbg_req),
    .busy_o    (busy)
  );

  function automatic logic [31:0] mk(input logic val, input logic pulse,
                                     input logic drnd, input int dur,
                                     input logic yrnd, input int dly);
    return {val, pulse, drnd, 13'(dur), yrnd, 15'(dly)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Write sampled on the next rising edge; returns at the negedge after it.
  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Counts negedges after the write edge: first one showing val, first idle one.
  task automatic run(input logic val, output int n_on, output int n_end, output bit bad);
    n_on  = -1;
    n_end = -1;
    bad   = 1'b0;
    for (int n = 1; n < 5000; n++) begin
      @(negedge clk);
      if (n_on < 0 && dbg_req == val) n_on = n;
      if (!busy) begin
        n_end = n;
        break;
      end
      if (n_on >= 0 && dbg_req != val) bad = 1'b1;
    end
  endtask

  task automatic prep(input logic v);
    int a, b;
    bit x;
    wr(mk(v, 1'b0, 1'b0, 0, 1'b0, 0));
    run(v, a, b, x);
  endtask

  initial begin
    int  on, fin;
    bit  bad;
    logic [7:0] seen;
    rst = 1'b1;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(dbg_req == 1'b0, "R1 req in reset", dbg_req, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dbg_req == 1'b0 && busy == 1'b0, "R1 after reset", {dbg_req, busy}, 0);

    // R3 R4: fixed-delay level sweep
    for (int d = 0; d < 8; d++) begin
      logic v;
      v = dbg_req ? 1'b0 : 1'b1;
      wr(mk(v, 1'b0, 1'b0, 0, 1'b0, d));
      chk(busy == 1'b1, "R2 busy after write", busy, 1);
      run(v, on, fin, bad);
      chk(on == d + 1, "R3 level delay", on, d + 1);
      chk(fin == d + 1, "R4 busy drop in level", fin, d + 1);
      chk(dbg_req == v, "R4 level value", dbg_req, v);
    end
    // R4 hold until next write
    begin
      logic held;
      held = dbg_req;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(dbg_req == held && !busy, "R4 level hold", dbg_req, held);
      end
    end

    // R5 R6: fixed pulse sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int d = 0; d < 4; d++) begin
        for (int p = 0; p < 5; p++) begin
          int pe;
          pe = (p == 0) ? 1 : p;
          prep(pol[0] ? 1'b0 : 1'b1);
          wr(mk(pol[0], 1'b1, 1'b0, p, 1'b0, d));
          run(pol[0], on, fin, bad);
          chk(on == d + 1, "R5 pulse start", on, d + 1);
          if (p == 0) chk(fin - on == 1, "R6 zero width pulse", fin - on, 1);
          else        chk(fin - on == pe, "R5 pulse width", fin - on, pe);
          chk(!bad, "R5 pulse steady", bad, 0);
          chk(dbg_req == ~pol[0], "R5 return level", dbg_req, ~pol[0]);
        end
      end
    end

    // R7 R9: random delay bounds and variety
    for (int mi = 0; mi < 3; mi++) begin
      int mx;
      mx = (mi == 0) ? 0 : (mi == 1) ? 3 : 7;
      seen = '0;
      for (int k = 0; k < 16; k++) begin
        logic v;
        v = dbg_req ? 1'b0 : 1'b1;
        repeat (k % 3) @(negedge clk);
        wr(mk(v, 1'b0, 1'b0, 0, 1'b1, mx));
        run(v, on, fin, bad);
        chk(fin - 1 >= 0 && fin - 1 <= mx, "R7 random delay range", fin - 1, mx);
        if (fin >= 1 && fin <= 8) seen[fin-1] = 1'b1;
      end
      if (mx == 0) chk(seen == 8'h01, "R7 zero max gives zero delay", seen, 1);
      if (mx == 7) chk($countones(seen) >= 2, "R9 draws vary", $countones(seen), 2);
    end

    // R8: random width bounds
    for (int mi = 0; mi < 2; mi++) begin
      int mx;
      mx = (mi == 0) ? 0 : 5;
      for (int k = 0; k < 12; k++) begin
        prep(1'b0);
        repeat (k % 4) @(negedge clk);
        wr(mk(1'b1, 1'b1, 1'b1, mx, 1'b0, 0));
        run(1'b1, on, fin, bad);
        if (mx == 0) chk(fin - on == 1, "R8 zero max width", fin - on, 1);
        else chk(fin - on >= 1 && fin - on <= mx, "R8 random width range", fin - on, mx);
      end
    end

    // R10: abort during delay
    prep(1'b0);
    wr(mk(1'b1, 1'b1, 1'b0, 5, 1'b0, 10));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dbg_req == 1'b0, "R10 hold during aborted delay", dbg_req, 0);
    end
    wr(mk(1'b1, 1'b0, 1'b0, 0, 1'b0, 2));
    run(1'b1, on, fin, bad);
    chk(on == 3 && fin == 3, "R10 restart after delay abort", on, 3);
    // R10: abort during pulse
    prep(1'b0);
    wr(mk(1'b1, 1'b1, 1'b0, 10, 1'b0, 0));
    repeat (4) @(negedge clk);
    chk(dbg_req == 1'b1 && busy, "R10 pulse running", dbg_req, 1);
    wr(mk(1'b0, 1'b0, 1'b0, 0, 1'b0, 3));
    run(1'b0, on, fin, bad);
    chk(on == 4 && fin == 4, "R10 restart after pulse abort", on, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule